// File: doc/BRIEF.md
# Stop-and-Go Keystream Generator

This block produces a pseudo-random bit stream from three linear feedback shift registers of different lengths. Each register has its own feedback taps. The control register advances on every enabled clock. Its output bit picks which one of the two data registers advances on that clock, and the other data register keeps its value. The stream bit is the XOR of the two data registers' output bits. Because the data registers advance irregularly, neither one's raw sequence appears directly at the output.

It is intended as a stimulus source, for example a test-pattern feed for a coder/decoder pair. The registers can be reseeded at run time. A seed of all zeros is replaced by a fixed nonzero value, because a linear shift register that holds only zeros never leaves that state.

Top module: `ssg_keystream`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `bit_out` to 0 and `bit_valid` to 0, and loads every register with its default seed (value 1 in its least significant bit). The reset takes priority over load and enable.
- R2: On an enabled cycle, the control register (default 7 bits) always advances. If its output bit (its most significant bit) is 1, data register B (default 9 bits) advances and C (default 11 bits) holds. If it is 0, C advances and B holds.
- R3: On each enabled cycle exactly one of B and C advances. On any other cycle no register advances.
- R4: On an enabled cycle, `bit_out` captures the XOR of the most significant bits of B and C as they stood before that edge.
- R5: While `en` is low (and `load` and `rst` are low), `bit_out`, `bit_valid` and all register contents hold.
- R6: `bit_valid` goes to 1 at the first enabled edge after reset and stays at 1 until the next reset.
- R7: With `load` high, each register takes the value on its seed port (bit i of the port into stage i). Load takes priority over `en`, no register advances, and `bit_out` and `bit_valid` keep their values.
- R8: A seed of all zeros is replaced by that register's default seed (value 1), so no register ever holds all zeros.
- R9: Each register advances in Fibonacci form. It shifts toward its most significant bit, and its new bit 0 is the XOR of bit N-1 and bit T-1, where (N,T) is (7,6) for A, (9,5) for B and (11,9) for C. These are primitive polynomials, so each register has a period of 2^N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the generator by one bit |
| load | input | 1 | Load all three seed ports |
| seed_a | input | A_LEN (7) | Seed for the control register |
| seed_b | input | B_LEN (9) | Seed for data register B |
| seed_c | input | C_LEN (11) | Seed for data register C |
| bit_out | output | 1 | Registered stream bit |
| bit_valid | output | 1 | High once a stream bit has been produced since reset |

## Verification
The assertions check on every cycle how the control bit steers the data registers: exactly one of B and C advances, and the other one's contents stay the same. They also check that no register ever reaches all zeros, that the output holds while idle or loading, that the stream bit follows the pre-edge XOR, and that valid stays high once set. Whether the feedback taps are right, and with them the whole bit sequence, can only be shown by the bench's scenarios. The bench compares the output bit by bit against a model written in stage-numbered form. It does this over a long free run, a gated-enable pattern, a sweep over all 128 control seeds (including zero seeds and loads asserted together with enable), and a reset in the middle of a run.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  // Widest register the shared step function supports.
  localparam int unsigned MAX_W = 31;

  // Per-cycle advance strobes for the three registers.
  typedef struct packed {
    logic ctl;
    logic dat_b;
    logic dat_c;
  } step_t;

  // One Fibonacci step of a w-bit register with taps at stages w and t.
  // Bits shift toward the MSB; the new LSB is s[w-1] ^ s[t-1].
  function automatic logic [MAX_W-1:0] fib_next(input logic [MAX_W-1:0] s,
                                                input int unsigned w,
                                                input int unsigned t);
    logic             fb;
    logic [MAX_W-1:0] keep;
    keep = (MAX_W'(1) << w) - MAX_W'(1);
    fb   = s[w-1] ^ s[t-1];
    return ((s << 1) | {{(MAX_W-1){1'b0}}, fb}) & keep;
  endfunction

  // Replace an all-zero seed by the register's nonzero default.
  function automatic logic [MAX_W-1:0] seed_fix(input logic [MAX_W-1:0] s,
                                                input logic [MAX_W-1:0] dflt);
    return (s == '0) ? dflt : s;
  endfunction

endpackage

// File: rtl/ssg_lfsr.sv
module ssg_lfsr
  import ssg_pkg::*;
#(
  parameter int unsigned W    = 7,
  parameter int unsigned T    = 6,
  parameter int unsigned DFLT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state,
  output logic         msb
);

  localparam logic [W-1:0] DFLT_V = W'(DFLT);

  logic [MAX_W-1:0] wide_next;
  logic [MAX_W-1:0] wide_seed;
  logic [W-1:0]     nxt;
  logic [W-1:0]     seed_ok;

  assign wide_next = fib_next(MAX_W'(state), W, T);
  assign wide_seed = seed_fix(MAX_W'(seed), MAX_W'(DFLT_V));
  assign nxt       = wide_next[W-1:0];
  assign seed_ok   = wide_seed[W-1:0];
  assign msb       = state[W-1];

  always_ff @(posedge clk) begin
    if (rst)       state <= DFLT_V;
    else if (load) state <= seed_ok;
    else if (step) state <= nxt;
  end

endmodule

// File: rtl/ssg_steer.sv
module ssg_steer
  import ssg_pkg::*;
(
  input  logic  rst,
  input  logic  en,
  input  logic  load,
  input  logic  ctl_bit,
  output step_t step
);

  always_comb begin
    step.ctl   = en & ~load & ~rst;
    step.dat_b = step.ctl &  ctl_bit;
    step.dat_c = step.ctl & ~ctl_bit;
  end

endmodule

// File: rtl/ssg_keystream.sv
module ssg_keystream
  import ssg_pkg::*;
#(
  parameter int unsigned A_LEN = 7,
  parameter int unsigned A_TAP = 6,
  parameter int unsigned B_LEN = 9,
  parameter int unsigned B_TAP = 5,
  parameter int unsigned C_LEN = 11,
  parameter int unsigned C_TAP = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [A_LEN-1:0] seed_a,
  input  logic [B_LEN-1:0] seed_b,
  input  logic [C_LEN-1:0] seed_c,
  output logic             bit_out,
  output logic             bit_valid
);

  step_t            step;
  logic [A_LEN-1:0] a_state;
  logic [B_LEN-1:0] b_state;
  logic [C_LEN-1:0] c_state;
  logic             a_msb;
  logic             b_msb;
  logic             c_msb;
  logic             mix_bit;

  ssg_steer u_steer (
    .rst     (rst),
    .en      (en),
    .load    (load),
    .ctl_bit (a_msb),
    .step    (step)
  );

  ssg_lfsr #(.W(A_LEN), .T(A_TAP), .DFLT(1)) u_ctl (
    .clk (clk), .rst (rst), .step (step.ctl), .load (load),
    .seed (seed_a), .state (a_state), .msb (a_msb)
  );

  ssg_lfsr #(.W(B_LEN), .T(B_TAP), .DFLT(1)) u_dat_b (
    .clk (clk), .rst (rst), .step (step.dat_b), .load (load),
    .seed (seed_b), .state (b_state), .msb (b_msb)
  );

  ssg_lfsr #(.W(C_LEN), .T(C_TAP), .DFLT(1)) u_dat_c (
    .clk (clk), .rst (rst), .step (step.dat_c), .load (load),
    .seed (seed_c), .state (c_state), .msb (c_msb)
  );

  assign mix_bit = b_msb ^ c_msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else if (step.ctl) begin
      bit_out   <= mix_bit;
      bit_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/ssg_keystream_chk.sv
module ssg_keystream_chk #(
  parameter int unsigned A_LEN = 7,
  parameter int unsigned B_LEN = 9,
  parameter int unsigned C_LEN = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             load,
  input logic             step_ctl,
  input logic             step_b,
  input logic             step_c,
  input logic             a_msb,
  input logic             b_msb,
  input logic             c_msb,
  input logic [A_LEN-1:0] a_state,
  input logic [B_LEN-1:0] b_state,
  input logic [C_LEN-1:0] c_state,
  input logic             bit_out,
  input logic             bit_valid
);

  // R3
  one_data_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_ctl |-> $onehot({step_b, step_c}));

  // R3
  no_stray_step_chk: assert property (@(posedge clk) disable iff (rst)
    !step_ctl |-> !step_b && !step_c);

  // R2
  c_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ctl && a_msb) |=> $stable(c_state));

  // R2
  b_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ctl && !a_msb) |=> $stable(b_state));

  // R4
  out_mix_chk: assert property (@(posedge clk) disable iff (rst)
    step_ctl |=> bit_out == $past(b_msb ^ c_msb));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(bit_out) && $stable(bit_valid) && $stable(a_state));

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> bit_valid);

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> $stable(bit_out) && $stable(bit_valid));

  // R8
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (a_state != '0) && (b_state != '0) && (c_state != '0));

endmodule

bind ssg_keystream ssg_keystream_chk #(
  .A_LEN (A_LEN), .B_LEN (B_LEN), .C_LEN (C_LEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .load      (load),
  .step_ctl  (step.ctl),
  .step_b    (step.dat_b),
  .step_c    (step.dat_c),
  .a_msb     (a_msb),
  .b_msb     (b_msb),
  .c_msb     (c_msb),
  .a_state   (a_state),
  .b_state   (b_state),
  .c_state   (c_state),
  .bit_out   (bit_out),
  .bit_valid (bit_valid)
);

// File: tb/ssg_keystream_test.sv
module ssg_keystream_test;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 7,  TA = 6;
  localparam int NB = 9,  TB = 5;
  localparam int NC = 11, TC = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          load = 1'b0;
  logic [NA-1:0] seed_a = '0;
  logic [NB-1:0] seed_b = '0;
  logic [NC-1:0] seed_c = '0;
  logic          bit_out;
  logic          bit_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model, stages numbered 1..N; stage N is the output.
  logic [NA:1] ma;
  logic [NB:1] mb;
  logic [NC:1] mc;
  logic        mout;
  logic        mvalid;

  ssg_keystream uut (
    .clk (clk), .rst (rst), .en (en), .load (load),
    .seed_a (seed_a), .seed_b (seed_b), .seed_c (seed_c),
    .bit_out (bit_out), .bit_valid (bit_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NA:1] adv_a(input logic [NA:1] r);
    return {r[NA-1:1], r[NA] ^ r[TA]};
  endfunction
  function automatic logic [NB:1] adv_b(input logic [NB:1] r);
    return {r[NB-1:1], r[NB] ^ r[TB]};
  endfunction
  function automatic logic [NC:1] adv_c(input logic [NC:1] r);
    return {r[NC-1:1], r[NC] ^ r[TC]};
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic e, input logic l,
                      input logic [NA-1:0] sa, input logic [NB-1:0] sb,
                      input logic [NC-1:0] sc, input string tag);
    logic sel;
    @(negedge clk);
    rst = r; en = e; load = l; seed_a = sa; seed_b = sb; seed_c = sc;
    @(posedge clk);
    if (r) begin
      ma = NA'(1); mb = NB'(1); mc = NC'(1); mout = 1'b0; mvalid = 1'b0;
    end else if (l) begin
      ma = (sa == '0) ? NA'(1) : sa;
      mb = (sb == '0) ? NB'(1) : sb;
      mc = (sc == '0) ? NC'(1) : sc;
    end else if (e) begin
      mout = mb[NB] ^ mc[NC];
      mvalid = 1'b1;
      sel = ma[NA];
      ma = adv_a(ma);
      if (sel) mb = adv_b(mb);
      else     mc = adv_c(mc);
    end
    #1;
    check(bit_out,   mout,   {tag, " bit_out"});
    check(bit_valid, mvalid, {tag, " bit_valid"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, '0, '0, '0, "R1 reset");
    // R6: valid after first enabled edge
    tick(1'b0, 1'b0, 1'b0, '0, '0, '0, "R6 idle before first bit");
    tick(1'b0, 1'b1, 1'b0, '0, '0, '0, "R6 first bit");
    // R2 R3 R4 R9: long free run from default seeds
    for (int i = 0; i < 2000; i++)
      tick(1'b0, 1'b1, 1'b0, '0, '0, '0, "R2 R3 R4 R9 free run");
    // R5: gated enable pattern
    for (int i = 0; i < 300; i++)
      tick(1'b0, (i % 3) != 0, 1'b0, '0, '0, '0, "R5 gated enable");
    // R7 R8: sweep every control seed, zero data seeds on some passes
    for (int v = 0; v < 128; v++) begin
      tick(1'b0, v[0], 1'b1, NA'(v),
           (v % 5 == 0) ? NB'(0) : NB'(v * 3 + 17),
           (v % 7 == 0) ? NC'(0) : NC'(v * 13 + 101),
           "R7 R8 load");
      for (int k = 0; k < 40; k++)
        tick(1'b0, 1'b1, 1'b0, '0, '0, '0, "R2 R4 R8 R9 after load");
    end
    // R1 R6: reset in mid-run with enable high
    tick(1'b1, 1'b1, 1'b1, 7'h55, 9'h0AA, 11'h155, "R1 mid-run reset");
    tick(1'b0, 1'b0, 1'b0, '0, '0, '0, "R6 idle after reset");
    for (int i = 0; i < 200; i++)
      tick(1'b0, 1'b1, 1'b0, '0, '0, '0, "R1 R6 restart");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule